// File: doc/BRIEF.md
# BCD Clock-Calendar Counter Chain

This block keeps wall-clock time and the calendar as a set of packed BCD register bytes: seconds, minutes, hours, day of the week, date, month and a two-digit year. A one-cycle pulse on `sec_tick` advances the time by one second. Carries ripple through the fields within that same clock edge. Month lengths and the leap-year rule are handled in hardware. Hours can be kept in a 24-hour or a 12-hour (AM/PM) representation, and the choice is held in the hour byte itself.

A host loads any field through a byte-wide write port: `wr_valid` qualifies `wr_addr` and `wr_data`. The port has no ready signal because the block never applies back-pressure, so each cycle with `wr_valid` high is one accepted write. The read port has no handshake either. `rd_data` is a combinational function of `rd_addr` and shows the formatted byte of the addressed field in the same cycle. A stop flag in the seconds byte freezes timekeeping while software sets the clock.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the fields read as follows. Address 0 (seconds) is 00h with the stop flag clear. Address 1 (minutes) is 00h, address 2 (hours) is 00h in 24-hour mode, address 3 (weekday) is 01h, address 4 (date) is 01h, address 5 (month) is 01h and address 6 (year) is 00h.
- R2: Seconds and minutes count 00 to 59 in BCD. A tick at 59 seconds gives 00 and advances minutes, and minutes rolling from 59 to 00 advances the hour.
- R3: Bit 7 of the seconds byte is a stop flag. While it is 1, ticks are ignored and every field holds its value. Writing it back to 0 resumes counting, and the flag reads back as written.
- R4: When hour bit 6 is 0 (24-hour mode), hours count 00h to 23h in BCD, with bit 5 as the twenties digit. 23h rolls to 00h and advances the weekday and the date.
- R5: When hour bit 6 is 1 (12-hour mode), bit 5 is the PM flag, bit 4 is the tens digit and hours run 01 to 12. The sequence is 51h (11 AM), then 72h (12 PM), then 61h (1 PM). It continues 71h (11 PM), then 52h (12 AM), then 41h (1 AM). Only the 11 PM to 12 AM step advances the weekday and the date.
- R6: The weekday counts 1 to 7 and wraps from 7 to 1 on a day advance.
- R7: On a day advance the date wraps to 01 and advances the month after 31 in months 01, 03, 05, 07, 08, 10 and 12, and after 30 in months 04, 06, 09 and 11.
- R8: February wraps after 29 when the BCD year is a multiple of 4 (including 00) and after 28 otherwise.
- R9: Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R10: A write replaces its field at the same edge, even when a tick would have changed that field. Carries into the other fields are still computed from the values held before the write.
- R11: Unused high bits read as 0. The stored bits are seconds [7:0], minutes [6:0], hours [6:0], weekday [2:0], date [5:0], month [4:0] and year [7:0], and written bits outside these are dropped. Address 7 reads 00h, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| wr_valid | input | 1 | Write strobe; always accepted |
| wr_addr | input | 3 | Field address for the write |
| wr_data | input | 8 | Register byte to write |
| rd_addr | input | 3 | Field address for the read |
| rd_data | output | 8 | Formatted register byte at rd_addr, combinational |

## Verification
A tick and a write presented in one cycle are both due on `rd_data` right after the next rising edge, with no further pipeline delay. A change of `rd_addr` shows on `rd_data` within the same cycle. The bench changes inputs on falling edges and reads all eight addresses in short steps starting 1 ns after the rising edge, before the next falling edge. Each expected byte comes from a reference calendar kept in plain integers: it first applies the tick to that reference and then lets the write override its field.

// File: rtl/bcd_cal_pkg.sv
`timescale 1ns/1ps
package bcd_cal_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned BYTE_W = 8;

  localparam logic [ADDR_W-1:0] ADR_SEC  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_MIN  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_HOUR = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_DOW  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_DATE = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_MON  = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_YEAR = 3'd6;

  // two-digit BCD increment without range limit
  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // value mod 4 equals (2*tens + ones) mod 4
  function automatic logic leap_year(input logic [7:0] yr);
    logic [1:0] rem;
    rem = yr[1:0] + {yr[4], 1'b0};
    return rem == 2'b00;
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_bcd60.sv
`timescale 1ns/1ps
module cal_bcd60
  import bcd_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [6:0] load_val_i,
  input  logic       inc_i,
  output logic [6:0] val_o,
  output logic       wrap_o
);
  logic [6:0] val_q;
  logic [7:0] val_inc;

  assign val_inc = bcd_next({1'b0, val_q});
  assign wrap_o  = (val_q >= 7'h59);
  assign val_o   = val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= 7'h00;
    else if (load_i) val_q <= load_val_i;
    else if (inc_i)  val_q <= wrap_o ? 7'h00 : val_inc[6:0];
  end

  // R2: a step at 59 lands on 00
  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i && val_q == 7'h59) |=> (val_q == 7'h00));

  // R10: a load wins over a same-cycle step
  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (val_q == $past(load_val_i)));
endmodule

// File: rtl/cal_time_chain.sv
`timescale 1ns/1ps
module cal_time_chain
  import bcd_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic              stop_o,
  output logic [6:0]        sec_o,
  output logic [6:0]        min_o,
  output logic [6:0]        hour_o,
  output logic              day_carry_o
);
  localparam int unsigned N_SEXA = 2;

  logic              stop_q;
  logic [6:0]        hour_q;
  logic [6:0]        hour_nx;
  logic              hour_roll;
  logic [7:0]        h24_inc;
  logic [7:0]        h12_inc;
  logic              step;
  logic              wr_sec;
  logic              wr_hour;
  logic [N_SEXA-1:0] sx_load;
  logic [N_SEXA-1:0] sx_inc;
  logic [N_SEXA-1:0] sx_wrap;
  logic [6:0]        sx_val [N_SEXA];
  logic              min_carry;

  assign wr_sec  = wr_valid_i && (wr_addr_i == ADR_SEC);
  assign wr_hour = wr_valid_i && (wr_addr_i == ADR_HOUR);
  assign step    = tick_i && !stop_q;

  assign sx_load[0] = wr_sec;
  assign sx_load[1] = wr_valid_i && (wr_addr_i == ADR_MIN);
  assign sx_inc[0]  = step;
  assign sx_inc[1]  = step && sx_wrap[0];

  genvar g;
  generate
    for (g = 0; g < N_SEXA; g++) begin : g_sexa
      cal_bcd60 u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (sx_load[g]),
        .load_val_i (wr_data_i[6:0]),
        .inc_i      (sx_inc[g]),
        .val_o      (sx_val[g]),
        .wrap_o     (sx_wrap[g])
      );
    end
  endgenerate

  assign min_carry = sx_inc[1] && sx_wrap[1];

  assign h24_inc = bcd_next({2'b00, hour_q[5:0]});
  assign h12_inc = bcd_next({3'b000, hour_q[4:0]});

  always_comb begin
    hour_nx   = hour_q;
    hour_roll = 1'b0;
    if (!hour_q[6]) begin
      if (hour_q[5:0] >= 6'h23) begin
        hour_nx   = 7'h00;
        hour_roll = 1'b1;
      end else begin
        hour_nx = {1'b0, h24_inc[5:0]};
      end
    end else if (hour_q[4:0] >= 5'h12) begin
      hour_nx = {1'b1, hour_q[5], 5'h01};
    end else if (hour_q[4:0] == 5'h11) begin
      hour_nx   = {1'b1, ~hour_q[5], 5'h12};
      hour_roll = hour_q[5];
    end else begin
      hour_nx = {1'b1, hour_q[5], h12_inc[4:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      hour_q <= 7'h00;
    end else begin
      if (wr_sec)         stop_q <= wr_data_i[7];
      if (wr_hour)        hour_q <= wr_data_i[6:0];
      else if (min_carry) hour_q <= hour_nx;
    end
  end

  assign stop_o      = stop_q;
  assign sec_o       = sx_val[0];
  assign min_o       = sx_val[1];
  assign hour_o      = hour_q;
  assign day_carry_o = min_carry && hour_roll;

  // R3: stop flag freezes the time fields
  a_r3_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !wr_valid_i) |=> ($stable(sx_val[0]) && $stable(sx_val[1]) && $stable(hour_q)));

  // R5: the mode bit only changes through a host write
  a_r5_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hour |=> $stable(hour_q[6]));

  // R5: 11 PM followed by a minute wrap leads to 12 AM
  a_r5_midnight_12h: assert property (@(posedge clk) disable iff (!rst_n)
    (min_carry && !wr_hour && hour_q == 7'h71) |=> (hour_q == 7'h52));
endmodule

// File: rtl/cal_date_chain.sv
`timescale 1ns/1ps
module cal_date_chain
  import bcd_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              day_carry_i,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [2:0]        dow_o,
  output logic [5:0]        date_o,
  output logic [4:0]        mon_o,
  output logic [7:0]        year_o
);
  logic [2:0] dow_q;
  logic [5:0] date_q;
  logic [4:0] mon_q;
  logic [7:0] year_q;
  logic [7:0] last_day;
  logic [7:0] date_inc;
  logic [7:0] mon_inc;
  logic [7:0] year_inc;
  logic       date_wrap;
  logic       mon_wrap;
  logic       mon_carry;
  logic       year_carry;
  logic       wr_dow, wr_date, wr_mon, wr_year;

  assign wr_dow  = wr_valid_i && (wr_addr_i == ADR_DOW);
  assign wr_date = wr_valid_i && (wr_addr_i == ADR_DATE);
  assign wr_mon  = wr_valid_i && (wr_addr_i == ADR_MON);
  assign wr_year = wr_valid_i && (wr_addr_i == ADR_YEAR);

  assign last_day   = month_last({3'b000, mon_q}, year_q);
  assign date_wrap  = ({2'b00, date_q} >= last_day);
  assign mon_wrap   = (mon_q >= 5'h12);
  assign mon_carry  = day_carry_i && date_wrap;
  assign year_carry = mon_carry && mon_wrap;

  assign date_inc = bcd_next({2'b00, date_q});
  assign mon_inc  = bcd_next({3'b000, mon_q});
  assign year_inc = bcd_next(year_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dow_q  <= 3'd1;
      date_q <= 6'h01;
      mon_q  <= 5'h01;
      year_q <= 8'h00;
    end else begin
      if (wr_dow)           dow_q <= wr_data_i[2:0];
      else if (day_carry_i) dow_q <= (dow_q >= 3'd7) ? 3'd1 : dow_q + 3'd1;

      if (wr_date)          date_q <= wr_data_i[5:0];
      else if (day_carry_i) date_q <= date_wrap ? 6'h01 : date_inc[5:0];

      if (wr_mon)           mon_q <= wr_data_i[4:0];
      else if (mon_carry)   mon_q <= mon_wrap ? 5'h01 : mon_inc[4:0];

      if (wr_year)          year_q <= wr_data_i;
      else if (year_carry)  year_q <= (year_q >= 8'h99) ? 8'h00 : year_inc;
    end
  end

  assign dow_o  = dow_q;
  assign date_o = date_q;
  assign mon_o  = mon_q;
  assign year_o = year_q;

  // R6: weekday wraps from 7 to 1
  a_r6_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry_i && !wr_valid_i && dow_q == 3'd7) |=> (dow_q == 3'd1));

  // R7: date restarts at 01 after the month's last day
  a_r7_date_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry_i && !wr_valid_i && date_q == last_day[5:0]) |=> (date_q == 6'h01));

  // R8: February 28 of a leap year steps to 29
  a_r8_leap_feb: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry_i && !wr_valid_i && mon_q == 5'h02 && date_q == 6'h28 && year_q[1:0] == 2'b00 && !year_q[4])
      |=> (date_q == 6'h29));

  // R9: year 99 wraps to 00 on a year carry
  a_r9_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (year_carry && !wr_valid_i && year_q == 8'h99) |=> (year_q == 8'h00));
endmodule

// File: rtl/cal_reg_view.sv
`timescale 1ns/1ps
module cal_reg_view
  import bcd_cal_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              stop_i,
  input  logic [6:0]        sec_i,
  input  logic [6:0]        min_i,
  input  logic [6:0]        hour_i,
  input  logic [2:0]        dow_i,
  input  logic [5:0]        date_i,
  input  logic [4:0]        mon_i,
  input  logic [7:0]        year_i,
  output logic [BYTE_W-1:0] data_o
);
  always_comb begin
    case (addr_i)
      ADR_SEC:  data_o = {stop_i, sec_i};
      ADR_MIN:  data_o = {1'b0, min_i};
      ADR_HOUR: data_o = {1'b0, hour_i};
      ADR_DOW:  data_o = {5'b00000, dow_i};
      ADR_DATE: data_o = {2'b00, date_i};
      ADR_MON:  data_o = {3'b000, mon_i};
      ADR_YEAR: data_o = year_i;
      default:  data_o = '0;
    endcase
  end
endmodule

// File: rtl/bcd_calendar_core.sv
`timescale 1ns/1ps
module bcd_calendar_core
  import bcd_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  logic       stop_w;
  logic [6:0] sec_w, min_w, hour_w;
  logic       day_carry_w;
  logic [2:0] dow_w;
  logic [5:0] date_w;
  logic [4:0] mon_w;
  logic [7:0] year_w;

  cal_time_chain u_time (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (sec_tick),
    .wr_valid_i  (wr_valid),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .stop_o      (stop_w),
    .sec_o       (sec_w),
    .min_o       (min_w),
    .hour_o      (hour_w),
    .day_carry_o (day_carry_w)
  );

  cal_date_chain u_date (
    .clk         (clk),
    .rst_n       (rst_n),
    .day_carry_i (day_carry_w),
    .wr_valid_i  (wr_valid),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .dow_o       (dow_w),
    .date_o      (date_w),
    .mon_o       (mon_w),
    .year_o      (year_w)
  );

  cal_reg_view u_view (
    .addr_i (rd_addr),
    .stop_i (stop_w),
    .sec_i  (sec_w),
    .min_i  (min_w),
    .hour_i (hour_w),
    .dow_i  (dow_w),
    .date_i (date_w),
    .mon_i  (mon_w),
    .year_i (year_w),
    .data_o (rd_data)
  );

  // R4: a day carry leaves the time fields at the start of a day
  a_r4_day_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry_w && !wr_valid) |=> (sec_w == 7'h00 && min_w == 7'h00 &&
                                    (hour_w == 7'h00 || hour_w == 7'h52)));
endmodule

// File: tb/bcd_calendar_core_tb_top.sv
`timescale 1ns/1ps
module bcd_calendar_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       wr_valid = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  // reference calendar in plain integers
  bit m_stop, m_12;
  int m_sec, m_min, m_h24, m_dow, m_date, m_mon, m_yr;

  always #2.5 clk = ~clk;

  bcd_calendar_core dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int days_in(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hour_byte(input int h24, input bit twelve);
    int h12;
    if (!twelve) return to_bcd(h24);
    h12 = (h24 % 12 == 0) ? 12 : h24 % 12;
    return 8'h40 | ((h24 >= 12) ? 8'h20 : 8'h00) | to_bcd(h12);
  endfunction

  function automatic logic [7:0] exp_byte(input int a);
    case (a)
      0: return {m_stop, to_bcd(m_sec)[6:0]};
      1: return to_bcd(m_min);
      2: return hour_byte(m_h24, m_12);
      3: return 8'(m_dow);
      4: return to_bcd(m_date);
      5: return to_bcd(m_mon);
      6: return to_bcd(m_yr);
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      0, 1: return "R2";
      2: return m_12 ? "R5" : "R4";
      3: return "R6";
      4: return "R7";
      5, 6: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic model_reset();
    m_stop = 0; m_12 = 0; m_sec = 0; m_min = 0; m_h24 = 0;
    m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0;
  endtask

  task automatic model_tick();
    if (m_stop) return;
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_h24++;
    if (m_h24 < 24) return;
    m_h24 = 0;
    m_dow = (m_dow >= 7) ? 1 : m_dow + 1;
    m_date++;
    if (m_date <= days_in(m_mon, m_yr)) return;
    m_date = 1; m_mon++;
    if (m_mon <= 12) return;
    m_mon = 1; m_yr = (m_yr + 1) % 100;
  endtask

  task automatic model_write(input int a, input logic [7:0] d);
    int h;
    case (a)
      0: begin m_stop = d[7]; m_sec = from_bcd({1'b0, d[6:0]}); end
      1: m_min = from_bcd({1'b0, d[6:0]});
      2: begin
        m_12 = d[6];
        if (d[6]) begin
          h = from_bcd({3'b000, d[4:0]});
          m_h24 = (h % 12) + (d[5] ? 12 : 0);
        end else begin
          m_h24 = from_bcd({2'b00, d[5:0]});
        end
      end
      3: m_dow = int'(d[2:0]);
      4: m_date = from_bcd({2'b00, d[5:0]});
      5: m_mon = from_bcd({3'b000, d[4:0]});
      6: m_yr = from_bcd(d);
      default: ;
    endcase
  endtask

  task automatic ck(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string force_tag);
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      #0.1;
      ck((force_tag == "") ? tag_of(a) : force_tag, rd_data, exp_byte(a));
    end
  endtask

  task automatic peek(input string tag, input int a, input logic [7:0] exp);
    rd_addr = 3'(a);
    #0.1;
    ck(tag, rd_data, exp);
  endtask

  // drive at falling edge, result due right after the next rising edge
  task automatic step(input bit t, input bit w, input int a, input logic [7:0] d);
    @(negedge clk);
    sec_tick = t; wr_valid = w; wr_addr = 3'(a); wr_data = d;
    @(posedge clk);
    #1;
    sec_tick = 1'b0; wr_valid = 1'b0;
    if (t) model_tick();
    if (w) model_write(a, d);
    check_all("");
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    step(1'b0, 1'b1, a, d);
  endtask

  task automatic tk();
    step(1'b1, 1'b0, 0, 8'h00);
  endtask

  task automatic end_of_day();
    wr(2, 8'h23); wr(1, 8'h59); wr(0, 8'h59);
  endtask

  function automatic logic [7:0] rand_byte(input int a);
    int v;
    case (a)
      0: begin
        v = ($urandom_range(0, 2) == 0) ? 59 : int'($urandom_range(0, 59));
        return {($urandom_range(0, 15) == 0), to_bcd(v)[6:0]};
      end
      1: begin
        v = ($urandom_range(0, 2) == 0) ? 59 : int'($urandom_range(0, 59));
        return to_bcd(v);
      end
      2: begin
        v = ($urandom_range(0, 1) == 0) ? (($urandom_range(0, 1) == 0) ? 23 : 11)
                                        : int'($urandom_range(0, 23));
        return hour_byte(v, 1'($urandom_range(0, 1)));
      end
      3: return 8'($urandom_range(1, 7));
      4: return to_bcd(($urandom_range(0, 1) == 0) ? int'($urandom_range(28, 31))
                                                   : int'($urandom_range(1, 31)));
      5: return to_bcd(int'($urandom_range(1, 12)));
      6: return to_bcd(($urandom_range(0, 3) == 0) ? 99 : int'($urandom_range(0, 99)));
      default: return 8'($urandom_range(0, 255));
    endcase
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL R1: watchdog expired, actual hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int a;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check_all("R1");

    // R2: seconds and minutes roll over
    wr(0, 8'h58); wr(1, 8'h59); wr(2, 8'h00);
    tk(); tk();
    peek("R2", 0, 8'h00); peek("R2", 1, 8'h00); peek("R2", 2, 8'h01);

    // R3: stop flag holds every field
    wr(0, 8'hB0);
    for (int i = 0; i < 5; i++) tk();
    peek("R3", 0, 8'hB0);
    wr(0, 8'h30); tk();
    peek("R3", 0, 8'h31);

    // R4: 24-hour day rollover
    wr(3, 8'h03); wr(4, 8'h10); wr(5, 8'h06); end_of_day(); tk();
    peek("R4", 2, 8'h00); peek("R4", 3, 8'h04); peek("R4", 4, 8'h11);

    // R5: 12-hour sequence
    wr(2, 8'h51); wr(1, 8'h59); wr(0, 8'h59); tk();
    peek("R5", 2, 8'h72);
    wr(1, 8'h59); wr(0, 8'h59); tk();
    peek("R5", 2, 8'h61);
    wr(3, 8'h07); wr(4, 8'h05);
    wr(2, 8'h71); wr(1, 8'h59); wr(0, 8'h59); tk();
    peek("R5", 2, 8'h52); peek("R6", 3, 8'h01); peek("R5", 4, 8'h06);
    wr(1, 8'h59); wr(0, 8'h59); tk();
    peek("R5", 2, 8'h41); peek("R5", 4, 8'h06);

    // R7: 30- and 31-day months
    wr(5, 8'h04); wr(4, 8'h30); end_of_day(); tk();
    peek("R7", 4, 8'h01); peek("R7", 5, 8'h05);
    wr(5, 8'h01); wr(4, 8'h30); end_of_day(); tk();
    peek("R7", 4, 8'h31); peek("R7", 5, 8'h01);
    end_of_day(); tk();
    peek("R7", 4, 8'h01); peek("R7", 5, 8'h02);

    // R8: February lengths
    wr(6, 8'h23); wr(5, 8'h02); wr(4, 8'h28); end_of_day(); tk();
    peek("R8", 4, 8'h01); peek("R8", 5, 8'h03);
    wr(6, 8'h24); wr(5, 8'h02); wr(4, 8'h28); end_of_day(); tk();
    peek("R8", 4, 8'h29);
    end_of_day(); tk();
    peek("R8", 4, 8'h01); peek("R8", 5, 8'h03);
    wr(6, 8'h00); wr(5, 8'h02); wr(4, 8'h28); end_of_day(); tk();
    peek("R8", 4, 8'h29);

    // R9: year end
    wr(6, 8'h99); wr(5, 8'h12); wr(4, 8'h31); end_of_day(); tk();
    peek("R9", 6, 8'h00); peek("R9", 5, 8'h01); peek("R9", 4, 8'h01);

    // R10: write wins at the same edge, carry from pre-write value
    wr(0, 8'h59); wr(1, 8'h10);
    step(1'b1, 1'b1, 1, 8'h33);
    peek("R10", 1, 8'h33); peek("R10", 0, 8'h00);
    wr(0, 8'h59); wr(1, 8'h20);
    step(1'b1, 1'b1, 0, 8'h05);
    peek("R10", 0, 8'h05); peek("R10", 1, 8'h21);

    // R11: spare address and masked bits
    wr(7, 8'hFF);
    peek("R11", 7, 8'h00);
    wr(3, 8'hFD);
    peek("R11", 3, 8'h05);
    wr(5, 8'hF2);
    peek("R11", 5, 8'h12);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      a = int'($urandom_range(0, 7));
      if ($urandom_range(0, 9) < 7)
        step(1'b1, ($urandom_range(0, 4) == 0), a, rand_byte(a));
      else
        wr(a, rand_byte(a));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule